// File: doc/BRIEF.md
# Performance-Event Counter Map

This block holds the association between hardware performance events and the programmable counter slots of a performance-monitoring unit. Software (through logic outside this block) presents a selector write for one counter index. The block checks the counter and the event, records the association, and answers with a one-cycle acknowledge or error strobe in the following cycle.

When the core reports an event, it presents a 20-bit event index together with a valid pulse. In the same cycle the block returns the counter that should advance, or an error strobe if the event has no usable counter. A separate combinational query port reports whether a given counter is counting cycles or retired instructions. Timers use this answer.

Event indices split into a 4-bit type in bits [19:16] and a 16-bit code in bits [15:0]. For cache-type events (type 1) the code splits further: bit [0] is the result, bits [2:1] are the operation, and bits [15:3] are the cache identifier.

Top module: `pmu_evmap`

## Requirements
- R1: After reset no event is mapped. `wr_ack` and `wr_err` are low, and every event pulse presented while `avail_mask` is nonzero raises `evt_err`.
- R2: A selector write is accepted only for a counter index that is at least 3, below NUM_CTRS, and whose `avail_mask` bit is set. Any other index gives `wr_err` in the cycle after the write and leaves the map unchanged.
- R3: Only these event indices are accepted: 0x00001 (cycles), 0x00002 (instructions), and three cache-type events with result bit 1. Those are 0x10019 (cache id 3, operation 0), 0x1001B (cache id 3, operation 1) and 0x10021 (cache id 4, operation 0). The event index is bits [19:0] of `sel_val`, and higher bits are ignored. Any other nonzero `sel_val` gives `wr_err` and adds no mapping.
- R4: An accepted write of a supported, unmapped event gives `wr_ack` in the next cycle. From that cycle on, the event maps to the written counter.
- R5: A write with `sel_val` equal to zero to a valid counter removes every mapping that targets that counter and gives `wr_ack`.
- R6: A write of an event that is already mapped gives `wr_ack` and leaves the existing mapping unchanged.
- R7: An event pulse whose event is mapped to a counter gives `inc_vld` with `inc_ctr` equal to that counter in the same cycle. This happens only if the counter is still valid under R2's rule and its `inhibit_mask` bit is clear.
- R8: An event pulse that is unsupported, unmapped, or maps to a counter that is invalid or inhibited raises `evt_err` for that cycle only. It does not raise `inc_vld`.
- R9: While `avail_mask` is all zero, event pulses raise neither `inc_vld` nor `evt_err`.
- R10: `qry_cyc` is high for counter 0 or for the counter mapped from event 0x00001. `qry_ins` is high for counter 2 or for the counter mapped from event 0x00002.
- R11: One counter can be the target of several events at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| avail_mask | input | NUM_CTRS | Counters present in this configuration |
| inhibit_mask | input | NUM_CTRS | Per-counter count-inhibit bits |
| sel_we | input | 1 | Selector write strobe |
| sel_ctr | input | CW | Counter index of the write |
| sel_val | input | SEL_W | Event selector value |
| wr_ack | output | 1 | Write accepted (cycle after `sel_we`) |
| wr_err | output | 1 | Write rejected (cycle after `sel_we`) |
| evt_vld | input | 1 | Event pulse |
| evt_code | input | 20 | Event index of the pulse |
| inc_vld | output | 1 | A counter should advance |
| inc_ctr | output | CW | Counter to advance (zero when `inc_vld` is low) |
| evt_err | output | 1 | Event pulse found no usable counter |
| qry_ctr | input | CW | Counter index being queried |
| qry_cyc | output | 1 | Queried counter counts cycles |
| qry_ins | output | 1 | Queried counter counts instructions |

## Verification
The map state is visible at the ports only through event pulses and queries. A corrupted or stale entry therefore appears the first time its event is pulsed or its counter is queried. A lost write appears in the cycle after the next access, because the error or acknowledge strobe registers one cycle after the write. The bench interleaves writes, pulses and queries with changing availability and inhibit masks, so that every entry is read back soon after each change.

// File: rtl/pmu_evmap_pkg.sv
package pmu_evmap_pkg;

   localparam int EVT_W     = 20;
   localparam int NSLOT     = 5;
   localparam int FIRST_PRG = 3;

   // slot order: cycles and instructions must be slots 0 and 1 (queried)
   localparam int SLOT_CYC  = 0;
   localparam int SLOT_INS  = 1;
   localparam int SLOT_DRD  = 2;
   localparam int SLOT_DWR  = 3;
   localparam int SLOT_IRD  = 4;

   localparam logic [3:0]  TYPE_HW    = 4'h0;
   localparam logic [3:0]  TYPE_CACHE = 4'h1;
   localparam logic [15:0] HW_CODE_CYC = 16'h0001;
   localparam logic [15:0] HW_CODE_INS = 16'h0002;

   localparam logic [12:0] CID_DTLB = 13'd3;
   localparam logic [12:0] CID_ITLB = 13'd4;
   localparam logic [1:0]  OP_RD    = 2'd0;
   localparam logic [1:0]  OP_WR    = 2'd1;
   localparam logic        RES_MISS = 1'b1;

   localparam int CYC_CTR = 0;
   localparam int INS_CTR = 2;

endpackage

// File: rtl/pmu_evmap_evdec.sv
module pmu_evmap_evdec
   import pmu_evmap_pkg::*;
(
   input  logic [EVT_W-1:0] evt,
   output logic [NSLOT-1:0] slot_oh,
   output logic             hit
);
   logic [3:0]  ev_type;
   logic [15:0] ev_code;
   logic [12:0] cache_id;
   logic [1:0]  cache_op;
   logic        cache_res;
   logic        is_hw, is_cache;

   always_comb begin
      ev_type   = evt[19:16];
      ev_code   = evt[15:0];
      cache_id  = ev_code[15:3];
      cache_op  = ev_code[2:1];
      cache_res = ev_code[0];
      is_hw     = (ev_type == TYPE_HW);
      is_cache  = (ev_type == TYPE_CACHE) && (cache_res == RES_MISS);

      slot_oh           = '0;
      slot_oh[SLOT_CYC] = is_hw && (ev_code == HW_CODE_CYC);
      slot_oh[SLOT_INS] = is_hw && (ev_code == HW_CODE_INS);
      slot_oh[SLOT_DRD] = is_cache && (cache_id == CID_DTLB) && (cache_op == OP_RD);
      slot_oh[SLOT_DWR] = is_cache && (cache_id == CID_DTLB) && (cache_op == OP_WR);
      slot_oh[SLOT_IRD] = is_cache && (cache_id == CID_ITLB) && (cache_op == OP_RD);
      hit               = |slot_oh;
   end
endmodule

// File: rtl/pmu_evmap_ctrchk.sv
module pmu_evmap_ctrchk #(
   parameter int NUM_CTRS  = 32,
   parameter int FIRST_PRG = 3,
   localparam int CW       = $clog2(NUM_CTRS)
) (
   input  logic [CW-1:0]       ctr,
   input  logic [NUM_CTRS-1:0] avail,
   input  logic [NUM_CTRS-1:0] inhib,
   output logic                valid,
   output logic                enabled
);
   always_comb begin
      valid   = (int'(ctr) >= FIRST_PRG) && (int'(ctr) < NUM_CTRS) && avail[ctr];
      enabled = valid && !inhib[ctr];
   end
endmodule

// File: rtl/pmu_evmap_store.sv
module pmu_evmap_store #(
   parameter int NSLOT = 5,
   parameter int CW    = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                set_en,
   input  logic [NSLOT-1:0]    set_oh,
   input  logic [CW-1:0]       set_ctr,
   input  logic                clr_en,
   input  logic [CW-1:0]       clr_ctr,
   output logic [NSLOT-1:0]    ent_vld,
   output logic [NSLOT*CW-1:0] ent_ctr
);
   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      logic          vld_q;
      logic [CW-1:0] ctr_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            ctr_q <= '0;
         end else if (set_en && set_oh[s]) begin
            vld_q <= 1'b1;
            ctr_q <= set_ctr;
         end else if (clr_en && vld_q && (ctr_q == clr_ctr)) begin
            vld_q <= 1'b0;
            ctr_q <= '0;
         end
      end
      assign ent_vld[s]             = vld_q;
      assign ent_ctr[s*CW +: CW]    = ctr_q;
   end
endmodule

// File: rtl/pmu_evmap.sv
module pmu_evmap
   import pmu_evmap_pkg::*;
#(
   parameter int NUM_CTRS = 32,
   parameter int SEL_W    = 64,
   localparam int CW      = $clog2(NUM_CTRS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_CTRS-1:0] avail_mask,
   input  logic [NUM_CTRS-1:0] inhibit_mask,
   input  logic                sel_we,
   input  logic [CW-1:0]       sel_ctr,
   input  logic [SEL_W-1:0]    sel_val,
   output logic                wr_ack,
   output logic                wr_err,
   input  logic                evt_vld,
   input  logic [EVT_W-1:0]    evt_code,
   output logic                inc_vld,
   output logic [CW-1:0]       inc_ctr,
   output logic                evt_err,
   input  logic [CW-1:0]       qry_ctr,
   output logic                qry_cyc,
   output logic                qry_ins
);
   if (NUM_CTRS < 4 || NUM_CTRS > 32) begin : g_bad_ctrs
      $error("pmu_evmap: NUM_CTRS must lie in 4..32");
   end
   if (SEL_W < EVT_W) begin : g_bad_sel
      $error("pmu_evmap: SEL_W must hold a full event index");
   end

   logic [NSLOT-1:0]    ent_vld;
   logic [NSLOT*CW-1:0] ent_ctr;

   // ---------------- selector write path ----------------
   logic [NSLOT-1:0] w_oh;
   logic             w_hit, w_ctr_ok, w_ctr_en_unused;
   logic             w_zero, w_dup;
   logic             set_en, clr_en, err_d, ack_d;

   pmu_evmap_evdec w_dec_i (
      .evt     (sel_val[EVT_W-1:0]),
      .slot_oh (w_oh),
      .hit     (w_hit)
   );

   pmu_evmap_ctrchk #(.NUM_CTRS(NUM_CTRS), .FIRST_PRG(FIRST_PRG)) w_chk_i (
      .ctr     (sel_ctr),
      .avail   (avail_mask),
      .inhib   (inhibit_mask),
      .valid   (w_ctr_ok),
      .enabled (w_ctr_en_unused)
   );

   always_comb begin
      w_zero = (sel_val == '0);
      w_dup  = |(w_oh & ent_vld);
      err_d  = sel_we && (!w_ctr_ok || (!w_zero && !w_hit));
      ack_d  = sel_we && !err_d;
      set_en = ack_d && !w_zero && !w_dup;
      clr_en = ack_d && w_zero;
   end

   pmu_evmap_store #(.NSLOT(NSLOT), .CW(CW)) store_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (set_en),
      .set_oh  (w_oh),
      .set_ctr (sel_ctr),
      .clr_en  (clr_en),
      .clr_ctr (sel_ctr),
      .ent_vld (ent_vld),
      .ent_ctr (ent_ctr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ack <= 1'b0;
         wr_err <= 1'b0;
      end else begin
         wr_ack <= ack_d;
         wr_err <= err_d;
      end
   end

   // ---------------- event lookup path ----------------
   logic [NSLOT-1:0] p_oh;
   logic             p_hit_unused, p_mapped, p_ctr_ok_unused, p_ctr_en, p_live;
   logic [CW-1:0]    p_ctr;

   pmu_evmap_evdec p_dec_i (
      .evt     (evt_code),
      .slot_oh (p_oh),
      .hit     (p_hit_unused)
   );

   always_comb begin
      p_ctr = '0;
      for (int s = 0; s < NSLOT; s++) begin
         if (p_oh[s]) p_ctr = p_ctr | ent_ctr[s*CW +: CW];
      end
      p_mapped = |(p_oh & ent_vld);
   end

   pmu_evmap_ctrchk #(.NUM_CTRS(NUM_CTRS), .FIRST_PRG(FIRST_PRG)) p_chk_i (
      .ctr     (p_ctr),
      .avail   (avail_mask),
      .inhib   (inhibit_mask),
      .valid   (p_ctr_ok_unused),
      .enabled (p_ctr_en)
   );

   always_comb begin
      p_live  = evt_vld && (|avail_mask);
      inc_vld = p_live && p_mapped && p_ctr_en;
      evt_err = p_live && !(p_mapped && p_ctr_en);
      inc_ctr = inc_vld ? p_ctr : '0;
   end

   // ---------------- monitor queries ----------------
   always_comb begin
      qry_cyc = (int'(qry_ctr) == CYC_CTR) ||
                (ent_vld[SLOT_CYC] && (ent_ctr[SLOT_CYC*CW +: CW] == qry_ctr));
      qry_ins = (int'(qry_ctr) == INS_CTR) ||
                (ent_vld[SLOT_INS] && (ent_ctr[SLOT_INS*CW +: CW] == qry_ctr));
   end

endmodule

// File: rtl/pmu_evmap_chk.sv
module pmu_evmap_chk #(
   parameter int NUM_CTRS = 32,
   parameter int SEL_W    = 64,
   localparam int CW      = $clog2(NUM_CTRS)
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_CTRS-1:0] avail_mask,
   input logic [NUM_CTRS-1:0] inhibit_mask,
   input logic                sel_we,
   input logic [CW-1:0]       sel_ctr,
   input logic [SEL_W-1:0]    sel_val,
   input logic                wr_ack,
   input logic                wr_err,
   input logic                evt_vld,
   input logic [19:0]         evt_code,
   input logic                inc_vld,
   input logic [CW-1:0]       inc_ctr,
   input logic                evt_err,
   input logic [CW-1:0]       qry_ctr,
   input logic                qry_cyc,
   input logic                qry_ins
);
   assert_wr_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sel_we |=> (wr_ack ^ wr_err));
   assert_no_stray_resp_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_we |=> (!wr_ack && !wr_err));
   assert_low_ctr_rejected_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_we && int'(sel_ctr) < 3) |=> wr_err);
   assert_inc_target_usable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      inc_vld |-> (int'(inc_ctr) >= 3 && avail_mask[inc_ctr] && !inhibit_mask[inc_ctr]));
   assert_pulse_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({inc_vld, evt_err}) && ((inc_vld || evt_err) -> evt_vld));
   assert_mask_zero_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (avail_mask == '0) |-> (!inc_vld && !evt_err));
   assert_fixed_cyc_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (qry_ctr == '0) |-> qry_cyc);
   assert_fixed_ins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(qry_ctr) == 2) |-> qry_ins);
endmodule

bind pmu_evmap pmu_evmap_chk #(.NUM_CTRS(NUM_CTRS), .SEL_W(SEL_W)) chk_i (.*);

// File: tb/pmu_evmap_tb_top.sv
module pmu_evmap_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NC = 32;
   localparam int CW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NC-1:0] avail_mask = '0, inhibit_mask = '0;
   logic          sel_we = 1'b0;
   logic [CW-1:0] sel_ctr = '0;
   logic [63:0]   sel_val = '0;
   logic          wr_ack, wr_err, evt_vld = 1'b0, inc_vld, evt_err, qry_cyc, qry_ins;
   logic [19:0]   evt_code = '0;
   logic [CW-1:0] inc_ctr, qry_ctr = '0;

   int vectors = 0, fails = 0;
   logic          m_vld [5];
   int            m_ctr [5];
   logic [19:0]   codes [5] = '{20'h00001, 20'h00002, 20'h10019, 20'h1001B, 20'h10021};

   always #(CLK_PERIOD/2) clk = ~clk;

   pmu_evmap dut_i (.*);

   function automatic int slot_of(logic [19:0] e);
      for (int i = 0; i < 5; i++) if (codes[i] == e) return i;
      return -1;
   endfunction

   function automatic bit ctr_ok(int c);
      return c >= 3 && c < NC && avail_mask[c];
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // called at a negedge; returns at the following negedge
   task automatic do_write(int c, logic [63:0] v, string req);
      bit ex_err;
      int s;
      sel_we = 1'b1; sel_ctr = CW'(c); sel_val = v;
      ex_err = 1'b0;
      if (!ctr_ok(c)) ex_err = 1'b1;
      else if (v == 0) begin
         for (int i = 0; i < 5; i++) if (m_vld[i] && m_ctr[i] == c) m_vld[i] = 1'b0;
      end else begin
         s = slot_of(v[19:0]);
         if (s < 0) ex_err = 1'b1;
         else if (!m_vld[s]) begin m_vld[s] = 1'b1; m_ctr[s] = c; end
      end
      @(negedge clk);
      chk(req, {wr_ack, wr_err}, {!ex_err, ex_err});
      sel_we = 1'b0;
   endtask

   task automatic do_pulse(logic [19:0] e, string req);
      int s, c;
      bit ex_inc, ex_err;
      evt_vld = 1'b1; evt_code = e;
      #1;
      s = slot_of(e);
      ex_inc = 0; ex_err = 0; c = 0;
      if (avail_mask != 0) begin
         if (s >= 0 && m_vld[s] && ctr_ok(m_ctr[s]) && !inhibit_mask[m_ctr[s]]) begin
            ex_inc = 1; c = m_ctr[s];
         end else ex_err = 1;
      end
      chk(req, {inc_vld, evt_err, 3'b0, inc_ctr}, {ex_inc, ex_err, 3'b0, 5'(c)});
      @(negedge clk);
      evt_vld = 1'b0;
   endtask

   task automatic do_query(int c, string req);
      bit ec, ei;
      qry_ctr = CW'(c);
      #1;
      ec = (c == 0) || (m_vld[0] && m_ctr[0] == c);
      ei = (c == 2) || (m_vld[1] && m_ctr[1] == c);
      chk(req, {qry_cyc, qry_ins}, {ec, ei});
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < 5; i++) begin m_vld[i] = 0; m_ctr[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      avail_mask = 32'h7FFF_FFF8;
      @(negedge clk);
      chk("R1 reset strobes", {wr_ack, wr_err}, 2'b00);
      for (int i = 0; i < 5; i++) do_pulse(codes[i], "R1 no mapping after reset");
      do_query(0, "R10 fixed cycles");
      do_query(2, "R10 fixed instructions");
      do_write(2, 64'h1, "R2 fixed counter rejected");
      do_write(31, 64'h1, "R2 unavailable counter rejected");
      do_pulse(20'h00001, "R2 rejected write left no map");
      do_write(5, 64'h10019, "R4 map dtlb read");
      do_pulse(20'h10019, "R4 R7 pulse hits counter 5");
      do_write(6, 64'h10019, "R6 duplicate acked");
      do_pulse(20'h10019, "R6 mapping unchanged");
      do_write(5, 64'h12345, "R3 unsupported rejected");
      do_pulse(20'h12345, "R3 unsupported pulse");
      do_write(5, 64'hABC0_0000_0000_0002, "R3 high bits ignored");
      do_write(5, 64'h1001B, "R11 third event on counter 5");
      do_pulse(20'h00002, "R11 instr on counter 5");
      do_pulse(20'h1001B, "R11 dtlb write on counter 5");
      do_query(5, "R10 mapped instr counter");
      inhibit_mask[5] = 1'b1;
      do_pulse(20'h10019, "R8 inhibited counter");
      inhibit_mask[5] = 1'b0;
      avail_mask = '0;
      do_pulse(20'h10019, "R9 mask zero ignored");
      avail_mask = 32'h7FFF_FFF8;
      do_write(5, 64'h0, "R5 erase counter 5");
      do_pulse(20'h10019, "R5 erased dtlb read");
      do_pulse(20'h00002, "R5 erased instr");
      do_query(5, "R5 R10 erased query");
      for (int n = 0; n < 1500; n++) begin
         int op;
         op = $urandom_range(0, 9);
         if (op < 4) begin
            logic [63:0] v;
            int k;
            k = $urandom_range(0, 7);
            v = {$urandom, $urandom};
            if (k < 5) v[19:0] = codes[k];
            else if (k == 5) v = 64'h0;
            do_write($urandom_range(0, NC-1), v, "R2 R3 R4 R5 R6 random write");
         end else if (op < 7) begin
            logic [19:0] e;
            e = ($urandom_range(0, 5) < 5) ? codes[$urandom_range(0, 4)] : 20'($urandom);
            do_pulse(e, "R7 R8 R9 random pulse");
         end else if (op < 9) begin
            do_query($urandom_range(0, NC-1), "R10 random query");
         end else begin
            inhibit_mask = $urandom & $urandom;
            avail_mask = ($urandom_range(0, 9) == 0) ? '0 : ($urandom | 32'h0000_0FF0);
         end
      end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule